// File: doc/BRIEF.md
# Accumulator Load Addressing-Mode Unit

This block carries out one accumulator load under a selectable addressing mode. A caller presents a 4-bit mode code, an address or immediate field, and the current program counter, index register and general register values. It then pulses `start`. The unit forms the effective address and reads a synchronous memory port once or twice, depending on the mode. It places the result in its accumulator and reports completion with a one-cycle `done` pulse.

The two auto-adjusting modes also produce a write-back value for the general register, with a strobe that coincides with `done`. All address arithmetic wraps modulo 2^AW. The memory returns data one cycle after a read request. Instruction decode, store operations and the memory itself live outside the block.

Top module: `acc_load_unit`

## Requirements
- R1: While `rst` is high and after it falls: `acc` is 0, and `done`, `illegal`, `wb_en` and `mem_rd_en` are all 0.
- R2: Mode 0 loads M[field]. Mode 6 loads M[rval[AW-1:0]]. Both issue exactly one memory read.
- R3: Mode 2 loads M[(pc + field) mod 2^AW]. Mode 4 loads M[(field + xr) mod 2^AW]. Both issue exactly one memory read.
- R4: Mode 1 issues two reads. The first is at `field`. The second is at the low AW bits of the word that the first read returns, and that second word is loaded.
- R5: Mode 3 loads `field` zero-extended to DW bits. Mode 5 loads the full `rval`. Neither issues a memory read.
- R6: Mode 7 loads M[rval[AW-1:0]]. It raises `wb_en` with `wb_data` = ((rval[AW-1:0] + 1) mod 2^AW), zero-extended.
- R7: Mode 8 loads M[(rval[AW-1:0] - 1) mod 2^AW]. It raises `wb_en` with `wb_data` equal to that decremented address, zero-extended.
- R8: `wb_en` is high only for modes 7 and 8, only in the cycle where `done` is high, and for one cycle.
- R9: Codes 9 to 15 raise `illegal` together with `done`. They issue no memory read and leave `acc` unchanged.
- R10: `done` is a one-cycle pulse. The edge that samples `start` sets it for register-only and illegal modes, the second edge after that for one-read modes, and the fourth edge for mode 1.
- R11: `start` is ignored while an operation is in progress. Inputs are captured only on the edge that accepts `start`.
- R12: `acc` changes only on the edge that raises `done`, and holds its value between operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| mode | input | 4 | Addressing-mode code |
| field | input | AW | Address or immediate field |
| pc | input | AW | Program counter value |
| xr | input | AW | Index register value |
| rval | input | DW | Selected general register value |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, valid one cycle after the request |
| acc | output | DW | Accumulator |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Unknown mode code, pulses with done |
| wb_en | output | 1 | General register write-back strobe |
| wb_data | output | DW | General register write-back value |

## Verification
The hardest case to reach is the indirect mode landing on a pointer that wraps. The second address comes from memory contents rather than from a port. The bench therefore fills memory with an arithmetic function of the address, so every pointer word is known in advance without storing a table. It then sweeps all sixteen codes against operand sets that sit at the top and bottom of the address space. This drives the relative, indexed and auto-adjust sums across the wrap boundary. A separate run holds `start` high and changes every input while a one-read load is in flight, to show that nothing after acceptance leaks in.

// File: rtl/acc_load_pkg.sv
package acc_load_pkg;

  typedef enum logic [3:0] {
    AM_DIRECT   = 4'd0,
    AM_INDIRECT = 4'd1,
    AM_RELATIVE = 4'd2,
    AM_IMMED    = 4'd3,
    AM_INDEXED  = 4'd4,
    AM_REGISTER = 4'd5,
    AM_REG_IND  = 4'd6,
    AM_POSTINC  = 4'd7,
    AM_PREDEC   = 4'd8
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA
  } seq_state_e;

  localparam int MODE_W = 4;

endpackage

// File: rtl/acc_ea_gen.sv
module acc_ea_gen
  import acc_load_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     field,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     xr,
  input  logic [DW-1:0]     rval,
  output logic [AW-1:0]     ea,
  output logic              needs_mem,
  output logic              two_reads,
  output logic [DW-1:0]     direct_val,
  output logic              is_auto,
  output logic [DW-1:0]     wb_val,
  output logic              legal
);

  logic [AW-1:0] raddr;
  logic [AW-1:0] rinc;
  logic [AW-1:0] rdec;

  assign raddr = rval[AW-1:0];
  assign rinc  = raddr + AW'(1);
  assign rdec  = raddr - AW'(1);

  always_comb begin
    ea         = '0;
    needs_mem  = 1'b1;
    two_reads  = 1'b0;
    direct_val = '0;
    is_auto    = 1'b0;
    wb_val     = '0;
    legal      = 1'b1;
    case (mode)
      AM_DIRECT:   ea = field;
      AM_INDIRECT: begin
        ea        = field;
        two_reads = 1'b1;
      end
      AM_RELATIVE: ea = pc + field;
      AM_IMMED: begin
        needs_mem  = 1'b0;
        direct_val = DW'(field);
      end
      AM_INDEXED:  ea = field + xr;
      AM_REGISTER: begin
        needs_mem  = 1'b0;
        direct_val = rval;
      end
      AM_REG_IND:  ea = raddr;
      AM_POSTINC: begin
        ea      = raddr;
        is_auto = 1'b1;
        wb_val  = DW'(rinc);
      end
      AM_PREDEC: begin
        ea      = rdec;
        is_auto = 1'b1;
        wb_val  = DW'(rdec);
      end
      default: begin
        legal     = 1'b0;
        needs_mem = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/acc_seq_fsm.sv
module acc_seq_fsm
  import acc_load_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          legal,
  input  logic          needs_mem,
  input  logic          two_reads,
  input  logic [AW-1:0] ea,
  input  logic [DW-1:0] direct_val,
  input  logic          is_auto,
  input  logic [DW-1:0] wb_val,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  output logic          ld_en,
  output logic [DW-1:0] ld_val,
  output logic          done,
  output logic          illegal,
  output logic          wb_en,
  output logic [DW-1:0] wb_data
);

  seq_state_e    state;
  logic          second_q;
  logic          auto_q;
  logic [DW-1:0] wb_hold;
  logic          accept;

  assign accept = (state == ST_IDLE) && start;

  // Accumulator load decision, registered by the top on the same edge as done
  always_comb begin
    ld_en  = 1'b0;
    ld_val = mem_rdata;
    if (accept && legal && !needs_mem) begin
      ld_en  = 1'b1;
      ld_val = direct_val;
    end else if (state == ST_DATA && !second_q) begin
      ld_en = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      second_q  <= 1'b0;
      auto_q    <= 1'b0;
      wb_hold   <= '0;
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
      done      <= 1'b0;
      illegal   <= 1'b0;
      wb_en     <= 1'b0;
      wb_data   <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      done      <= 1'b0;
      illegal   <= 1'b0;
      wb_en     <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (!legal) begin
              done    <= 1'b1;
              illegal <= 1'b1;
            end else if (!needs_mem) begin
              done <= 1'b1;
            end else begin
              mem_rd_en <= 1'b1;
              mem_addr  <= ea;
              second_q  <= two_reads;
              auto_q    <= is_auto;
              wb_hold   <= wb_val;
              state     <= ST_WAIT;
            end
          end
        end
        ST_WAIT: state <= ST_DATA;
        ST_DATA: begin
          if (second_q) begin
            second_q  <= 1'b0;
            mem_rd_en <= 1'b1;
            mem_addr  <= mem_rdata[AW-1:0];
            state     <= ST_WAIT;
          end else begin
            done    <= 1'b1;
            wb_en   <= auto_q;
            wb_data <= wb_hold;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/acc_load_unit.sv
module acc_load_unit
  import acc_load_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     field,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     xr,
  input  logic [DW-1:0]     rval,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_addr,
  input  logic [DW-1:0]     mem_rdata,
  output logic [DW-1:0]     acc,
  output logic              done,
  output logic              illegal,
  output logic              wb_en,
  output logic [DW-1:0]     wb_data
);

  logic [AW-1:0] ea;
  logic          needs_mem;
  logic          two_reads;
  logic [DW-1:0] direct_val;
  logic          is_auto;
  logic [DW-1:0] wb_val;
  logic          legal;
  logic          ld_en;
  logic [DW-1:0] ld_val;

  acc_ea_gen #(.AW(AW), .DW(DW)) u_ea (
    .mode       (mode),
    .field      (field),
    .pc         (pc),
    .xr         (xr),
    .rval       (rval),
    .ea         (ea),
    .needs_mem  (needs_mem),
    .two_reads  (two_reads),
    .direct_val (direct_val),
    .is_auto    (is_auto),
    .wb_val     (wb_val),
    .legal      (legal)
  );

  acc_seq_fsm #(.AW(AW), .DW(DW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .legal      (legal),
    .needs_mem  (needs_mem),
    .two_reads  (two_reads),
    .ea         (ea),
    .direct_val (direct_val),
    .is_auto    (is_auto),
    .wb_val     (wb_val),
    .mem_rdata  (mem_rdata),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .ld_en      (ld_en),
    .ld_val     (ld_val),
    .done       (done),
    .illegal    (illegal),
    .wb_en      (wb_en),
    .wb_data    (wb_data)
  );

  always_ff @(posedge clk) begin
    if (rst)        acc <= '0;
    else if (ld_en) acc <= ld_val;
  end

endmodule

// File: rtl/acc_load_chk.sv
module acc_load_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_rd_en,
  input logic          done,
  input logic          illegal,
  input logic          wb_en,
  input logic [DW-1:0] acc
);

  p_wb_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> done);

  p_wb_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> !wb_en);

  p_illegal_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> done);

  p_illegal_keeps_acc_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $stable(acc));

  p_illegal_no_read_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !mem_rd_en);

  p_read_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  p_read_not_done_r10: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !done);

  p_acc_moves_with_done_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(acc) |-> done);

endmodule

bind acc_load_unit acc_load_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_rd_en (mem_rd_en),
  .done      (done),
  .illegal   (illegal),
  .wb_en     (wb_en),
  .acc       (acc)
);

// File: tb/acc_load_unit_bench.sv
`timescale 1ns/1ps
module acc_load_unit_bench;

  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [3:0]    mode = '0;
  logic [AW-1:0] field = '0;
  logic [AW-1:0] pc = '0;
  logic [AW-1:0] xr = '0;
  logic [DW-1:0] rval = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] acc;
  logic          done;
  logic          illegal;
  logic          wb_en;
  logic [DW-1:0] wb_data;

  int checks = 0;
  int errors = 0;
  int rd_count = 0;
  logic [DW-1:0] model_acc = '0;

  always #2.5 clk = ~clk;

  acc_load_unit #(.AW(AW), .DW(DW)) u_acc_load_unit (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .field(field),
    .pc(pc), .xr(xr), .rval(rval), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .acc(acc), .done(done),
    .illegal(illegal), .wb_en(wb_en), .wb_data(wb_data)
  );

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    logic [DW-1:0] t;
    t = DW'(a) * 16'd40503 + 16'h1235;
    return t;
  endfunction

  // Memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= memf(mem_addr);
      rd_count = rd_count + 1;
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] m, input logic [AW-1:0] f,
                        input logic [AW-1:0] p, input logic [AW-1:0] x,
                        input logic [DW-1:0] r);
    string tag;
    logic [DW-1:0] e_acc;
    int e_lat, e_rd, n, r0;
    logic e_wb, e_ill, early_wb;
    logic [DW-1:0] e_wbd;
    logic [AW-1:0] ra;
    ra = r[AW-1:0];
    e_acc = model_acc; e_wb = 1'b0; e_wbd = '0; e_ill = 1'b0;
    e_lat = 3; e_rd = 1;
    case (m)
      4'd0: begin tag = "R2"; e_acc = memf(f); end
      4'd1: begin tag = "R4"; e_acc = memf(memf(f)[AW-1:0]); e_lat = 5; e_rd = 2; end
      4'd2: begin tag = "R3"; e_acc = memf(AW'(p + f)); end
      4'd3: begin tag = "R5"; e_acc = DW'(f); e_lat = 1; e_rd = 0; end
      4'd4: begin tag = "R3"; e_acc = memf(AW'(f + x)); end
      4'd5: begin tag = "R5"; e_acc = r; e_lat = 1; e_rd = 0; end
      4'd6: begin tag = "R2"; e_acc = memf(ra); end
      4'd7: begin tag = "R6"; e_acc = memf(ra); e_wb = 1'b1; e_wbd = DW'(AW'(ra + 1)); end
      4'd8: begin tag = "R7"; e_acc = memf(AW'(ra - 1)); e_wb = 1'b1; e_wbd = DW'(AW'(ra - 1)); end
      default: begin tag = "R9"; e_ill = 1'b1; e_lat = 1; e_rd = 0; end
    endcase
    @(negedge clk);
    mode = m; field = f; pc = p; xr = x; rval = r; start = 1'b1;
    r0 = rd_count; n = 0; early_wb = 1'b0;
    do begin
      @(negedge clk);
      start = 1'b0;
      n++;
      if (wb_en && !done) early_wb = 1'b1;
    end while (!done && n < 20);
    check("R10", "latency", n, e_lat);
    check(tag, "acc", acc, e_acc);
    check(tag, "reads", rd_count - r0, e_rd);
    check("R9", "illegal", illegal, e_ill);
    check("R8", "wb_en", wb_en, e_wb);
    check("R8", "wb before done", early_wb, 1'b0);
    if (e_wb) check(tag, "wb_data", wb_data, e_wbd);
    model_acc = e_acc;
    @(negedge clk);
    check("R10", "done pulse", done, 1'b0);
    check("R8", "wb pulse", wb_en, 1'b0);
    check("R12", "acc hold", acc, model_acc);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "acc reset", acc, 0);
    check("R1", "done reset", done, 0);
    check("R1", "illegal reset", illegal, 0);
    check("R1", "wb_en reset", wb_en, 0);
    check("R1", "rd_en reset", mem_rd_en, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "acc after reset", acc, 0);

    for (int s = 0; s < 8; s++) begin
      logic [AW-1:0] f, p, x;
      logic [DW-1:0] r;
      case (s)
        0: begin f = 12'h010; p = 12'h100; x = 12'h005; r = 16'h0020; end
        1: begin f = 12'hFFF; p = 12'h001; x = 12'h001; r = 16'h0FFF; end
        2: begin f = 12'h000; p = 12'hFFF; x = 12'hFFF; r = 16'h0000; end
        3: begin f = 12'hABC; p = 12'h555; x = 12'h123; r = 16'hF800; end
        4: begin f = 12'h7FF; p = 12'h801; x = 12'h801; r = 16'h7001; end
        default: begin
          f = AW'(s * 613 + 77); p = AW'(s * 1291); x = AW'(s * 409 + 3);
          r = DW'(s * 7919);
        end
      endcase
      for (int m = 0; m < 16; m++) run_op(4'(m), f, p, x, r);
    end

    // R11: start held high and inputs changed while a direct load runs
    begin
      int n;
      int r0;
      @(negedge clk);
      mode = 4'd0; field = 12'h345; start = 1'b1; r0 = rd_count; n = 0;
      do begin
        @(negedge clk);
        n++;
        mode = 4'd3; field = 12'h055; rval = 16'hBEEF;
      end while (!done && n < 20);
      start = 1'b0;
      check("R11", "latency while held", n, 3);
      check("R11", "acc while held", acc, memf(12'h345));
      check("R11", "reads while held", rd_count - r0, 1);
      model_acc = memf(12'h345);
      @(negedge clk);
      check("R11", "no restart", done, 1'b0);
      repeat (3) @(negedge clk);
      check("R12", "acc idle hold", acc, model_acc);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule